// File: doc/BRIEF.md
# Word-Access Transfer Buffer Port

This block is a 512-byte staging store placed between a 32-bit register interface and a flash sequencer. The host side reaches the store only through one data register. A control register loads a word pointer and selects the transfer direction. Host writes through the data register fill the store before an outgoing transfer. Host reads through the data register drain it after an incoming transfer. When auto-increment is on, every data access steps the word pointer by one word.

The sequencer has its own byte-wide port. A separate offset register sets the byte at which the sequencer starts. A start pulse loads the sequencer's byte pointer from that offset, and each byte access then steps the pointer. Bytes are packed little-endian. A transfer whose length is not a multiple of four ends with one whole-word host access, and only the low bytes of that word are meaningful.

Host data accesses and sequencer accesses share the store. When both arrive in the same cycle, the sequencer is served first and the host access is held for one cycle.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset the direction bit, auto-increment bit, word pointer and sequencer offset are all 0, `host_ready` is 1 and `host_ack` is 0.
- R2: A host write to the control register (`host_sel`=0) sets direction from bit 31 and auto-increment from bit 30. It loads the word pointer from bits 7:0 taken modulo 128. A control read returns the direction in bit 31, auto-increment in bit 30 and the current word pointer in bits 6:0, with all other bits 0.
- R3: A host write to the data register (`host_sel`=1) with direction 1 stores the 32-bit word at the word pointer. The pointer advances by one only when auto-increment is 1.
- R4: A host read of the data register with direction 0 returns the word at the pointer. The pointer advances by one only when auto-increment is 1.
- R5: A host read of the data register with direction 1 returns the word at the pointer and leaves the pointer unchanged, even with auto-increment set.
- R6: A host write to the data register with direction 0 is ignored: the store and the pointer are unchanged.
- R7: The word pointer wraps from 127 to 0.
- R8: Byte address 4·w+b of the sequencer port is bits 8·b+7:8·b of word w (little-endian), in both directions.
- R9: The offset register (`host_sel`=2, bits 8:0, read back in bits 8:0) is where a `seq_start` pulse loads the sequencer byte pointer. An access with `seq_start` uses the offset itself. Each sequencer access advances the byte pointer by one, wrapping from 511 to 0.
- R10: A host data-register access and a `seq_en` access in the same cycle is a collision. In that case the sequencer access is performed in that cycle, `host_ready` is 0 in the next cycle, and the host access completes one cycle later than it would without the collision.
- R11: An accepted host request that does not collide raises `host_ack` for one cycle right after the accepting edge, with `host_rdata` valid for reads. A sequencer read returns `seq_rbyte` with `seq_rvalid` right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host register access request, taken when `host_ready` is 1 |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_sel | input | 2 | 0 control, 1 data, 2 sequencer offset, 3 unused |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | 0 while a deferred host access is pending |
| host_ack | output | 1 | Host access completed |
| host_rdata | output | 32 | Host read data, valid with `host_ack` |
| seq_en | input | 1 | Sequencer byte access |
| seq_start | input | 1 | Load sequencer byte pointer from offset |
| seq_we | input | 1 | 1 = sequencer byte write |
| seq_wbyte | input | 8 | Sequencer write byte |
| seq_rvalid | output | 1 | Sequencer read byte valid |
| seq_rbyte | output | 8 | Sequencer read byte |

## Verification
The two functions that can meet in one cycle are a host data-register access and a sequencer byte access. The bench provokes this by raising `host_req` for a data read and `seq_en` on the same clock. It expects the sequencer's byte back right after that edge, with `host_ready` low and no `host_ack`. One edge later it expects `host_ack` with the correct word, and it then confirms that the word pointer advanced exactly once.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int CTL_DIR_BIT = 31;
    localparam int CTL_INC_BIT = 30;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic              we;
        host_sel_e         sel;
        logic [DATA_W-1:0] wdata;
    } host_op_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic dir, input logic inc,
                                                    input logic [7:0] ptr);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTL_DIR_BIT] = dir;
        v[CTL_INC_BIT] = inc;
        v[7:0] = ptr;
        return v;
    endfunction

endpackage

// File: rtl/xbp_arbiter.sv
module xbp_arbiter
    import xbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              seq_en,
    output logic              host_ready,
    output logic              host_ack,
    output logic              exec_vld,
    output host_op_t          exec_op
);

    host_op_t live_op, held_q;
    logic     pending_q, accept, clash;

    always_comb begin
        live_op.we    = host_we;
        live_op.sel   = host_sel_e'(host_sel);
        live_op.wdata = host_wdata;
        accept   = host_req && !pending_q;
        clash    = accept && (live_op.sel == SEL_DATA) && seq_en;
        exec_vld = (accept && !clash) || pending_q;
        exec_op  = pending_q ? held_q : live_op;
    end

    assign host_ready = !pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            host_ack  <= 1'b0;
            held_q    <= '0;
        end else begin
            pending_q <= clash;
            host_ack  <= exec_vld;
            if (clash) held_q <= live_op;
        end
    end

    AST_DEFER_ON_CLASH: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready && host_sel == SEL_DATA && seq_en) |=> (!host_ready && !host_ack)); // R10
    AST_DEFER_DONE: assert property (@(posedge clk) disable iff (rst)
        !host_ready |=> (host_ack && host_ready)); // R10
    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready && !(seq_en && host_sel == SEL_DATA)) |=> host_ack); // R11

endmodule

// File: rtl/xbp_host_regs.sv
module xbp_host_regs
    import xbp_pkg::*;
#(
    parameter int WPTR_W = 7,
    parameter int BPTR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_vld,
    input  host_op_t          exec_op,
    input  logic [DATA_W-1:0] word_rdata,
    output logic              word_we,
    output logic [WPTR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word_wdata,
    output logic [BPTR_W-1:0] offset,
    output logic [DATA_W-1:0] host_rdata
);

    logic              dir_q, inc_q;
    logic [WPTR_W-1:0] wptr_q;
    logic              is_data, wr_data, rd_data, advance;
    logic [DATA_W-1:0] rd_next;
    logic              unused_ok;

    always_comb begin
        is_data = exec_vld && (exec_op.sel == SEL_DATA);
        wr_data = is_data && exec_op.we && dir_q;
        rd_data = is_data && !exec_op.we;
        advance = inc_q && (wr_data || (rd_data && !dir_q));
        unique case (exec_op.sel)
            SEL_CTRL: rd_next = pack_ctrl(dir_q, inc_q, 8'(wptr_q));
            SEL_DATA: rd_next = word_rdata;
            SEL_OFFS: rd_next = DATA_W'(offset);
            default:  rd_next = '0;
        endcase
    end

    assign word_we    = wr_data;
    assign word_addr  = wptr_q;
    assign word_wdata = exec_op.wdata;
    assign unused_ok  = ^exec_op.wdata[CTL_INC_BIT-1:BPTR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q      <= 1'b0;
            inc_q      <= 1'b0;
            wptr_q     <= '0;
            offset     <= '0;
            host_rdata <= '0;
        end else begin
            if (exec_vld && exec_op.we && exec_op.sel == SEL_CTRL) begin
                dir_q  <= exec_op.wdata[CTL_DIR_BIT];
                inc_q  <= exec_op.wdata[CTL_INC_BIT];
                wptr_q <= exec_op.wdata[WPTR_W-1:0];
            end else if (advance) begin
                wptr_q <= wptr_q + WPTR_W'(1);
            end
            if (exec_vld && exec_op.we && exec_op.sel == SEL_OFFS)
                offset <= exec_op.wdata[BPTR_W-1:0];
            if (exec_vld && !exec_op.we)
                host_rdata <= rd_next;
        end
    end

    AST_DIR1_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data && dir_q) |=> $stable(wptr_q)); // R5
    AST_DIR0_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (is_data && exec_op.we && !dir_q) |=> $stable(wptr_q)); // R6
    AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_data && inc_q) |=> (wptr_q == $past(wptr_q) + WPTR_W'(1))); // R3

endmodule

// File: rtl/xbp_seq_port.sv
module xbp_seq_port #(
    parameter int BPTR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic              seq_start,
    input  logic [BPTR_W-1:0] offset,
    output logic [BPTR_W-1:0] byte_addr
);

    logic [BPTR_W-1:0] bptr_q;

    assign byte_addr = seq_start ? offset : bptr_q;

    always_ff @(posedge clk) begin
        if (rst)            bptr_q <= '0;
        else if (seq_en)    bptr_q <= byte_addr + BPTR_W'(1);
        else if (seq_start) bptr_q <= offset;
    end

    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !seq_start) |=> (bptr_q == $past(bptr_q) + BPTR_W'(1))); // R9
    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (seq_start && !seq_en) |=> (bptr_q == $past(offset))); // R9

endmodule

// File: rtl/xbp_store.sv
module xbp_store
    import xbp_pkg::*;
#(
    parameter int WORDS  = 128,
    parameter int WPTR_W = 7,
    parameter int BPTR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w_we,
    input  logic [WPTR_W-1:0] w_addr,
    input  logic [DATA_W-1:0] w_wdata,
    output logic [DATA_W-1:0] w_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [BPTR_W-1:0] b_addr,
    input  logic [7:0]        b_wdata,
    output logic              b_rvalid,
    output logic [7:0]        b_rdata
);

    logic [LANES-1:0][7:0] mem [WORDS];
    logic [WPTR_W-1:0]     b_word;
    logic [1:0]            b_lane;

    assign b_word  = b_addr[BPTR_W-1:2];
    assign b_lane  = b_addr[1:0];
    assign w_rdata = mem[w_addr];

    always_ff @(posedge clk) begin
        for (int ln = 0; ln < LANES; ln++) begin
            if (w_we)
                mem[w_addr][ln] <= w_wdata[8*ln +: 8];
            else if (b_en && b_we && b_lane == 2'(ln))
                mem[b_word][ln] <= b_wdata;
        end
        if (w_we && b_en && b_we && b_word != w_addr)
            mem[b_word][b_lane] <= b_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_rvalid <= 1'b0;
            b_rdata  <= '0;
        end else begin
            b_rvalid <= b_en && !b_we;
            if (b_en && !b_we) b_rdata <= mem[b_word][b_lane];
        end
    end

    AST_BYTE_RVALID: assert property (@(posedge clk) disable iff (rst)
        (b_en && !b_we) |=> b_rvalid); // R11

endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port
    import xbp_pkg::*;
#(
    parameter int BUF_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic        host_ack,
    output logic [31:0] host_rdata,
    input  logic        seq_en,
    input  logic        seq_start,
    input  logic        seq_we,
    input  logic [7:0]  seq_wbyte,
    output logic        seq_rvalid,
    output logic [7:0]  seq_rbyte
);

    localparam int WORDS  = BUF_BYTES / LANES;
    localparam int WPTR_W = $clog2(WORDS);
    localparam int BPTR_W = $clog2(BUF_BYTES);

    logic              exec_vld, word_we;
    host_op_t          exec_op;
    logic [WPTR_W-1:0] word_addr;
    logic [DATA_W-1:0] word_wdata, word_rdata;
    logic [BPTR_W-1:0] offset, byte_addr;

    xbp_arbiter u_arb (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .seq_en(seq_en),
        .host_ready(host_ready), .host_ack(host_ack),
        .exec_vld(exec_vld), .exec_op(exec_op)
    );

    xbp_host_regs #(.WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_regs (
        .clk(clk), .rst(rst), .exec_vld(exec_vld), .exec_op(exec_op),
        .word_rdata(word_rdata), .word_we(word_we), .word_addr(word_addr),
        .word_wdata(word_wdata), .offset(offset), .host_rdata(host_rdata)
    );

    xbp_seq_port #(.BPTR_W(BPTR_W)) u_seq (
        .clk(clk), .rst(rst), .seq_en(seq_en), .seq_start(seq_start),
        .offset(offset), .byte_addr(byte_addr)
    );

    xbp_store #(.WORDS(WORDS), .WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) u_store (
        .clk(clk), .rst(rst), .w_we(word_we), .w_addr(word_addr),
        .w_wdata(word_wdata), .w_rdata(word_rdata),
        .b_en(seq_en), .b_we(seq_we), .b_addr(byte_addr), .b_wdata(seq_wbyte),
        .b_rvalid(seq_rvalid), .b_rdata(seq_rbyte)
    );

endmodule

// File: tb/tb_xfer_buf_port.sv
`timescale 1ns/1ps
module tb_xfer_buf_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_ack;
    logic [31:0] host_rdata;
    logic        seq_en = 1'b0, seq_start = 1'b0, seq_we = 1'b0;
    logic [7:0]  seq_wbyte = '0;
    logic        seq_rvalid;
    logic [7:0]  seq_rbyte;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xfer_buf_port dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [1:0] sel,
                           input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        chk(host_ack === 1'b1, "R11", "host ack", 32'(host_ack), 32'd1);
        rd = host_rdata;
    endtask

    task automatic seq_op(input logic start, input logic we, input logic [7:0] wb,
                          output logic [7:0] rb);
        @(negedge clk);
        seq_en = 1'b1; seq_start = start; seq_we = we; seq_wbyte = wb;
        @(posedge clk);
        @(negedge clk);
        seq_en = 1'b0; seq_start = 1'b0; seq_we = 1'b0;
        if (!we) chk(seq_rvalid === 1'b1, "R11", "seq rvalid", 32'(seq_rvalid), 32'd1);
        rb = seq_rbyte;
    endtask

    task automatic set_ctrl(input logic dir, input logic inc, input logic [7:0] a);
        logic [31:0] d;
        host_op(1'b1, 2'd0, {dir, inc, 22'd0, a}, d);
    endtask

    task automatic expect_ptr(input logic [6:0] p, input string req);
        logic [31:0] d;
        host_op(1'b0, 2'd0, 32'd0, d);
        chk(d[6:0] === p, req, "word pointer", 32'(d[6:0]), 32'(p));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(host_ready === 1'b1 && host_ack === 1'b0, "R1", "ready/ack",
            {30'd0, host_ready, host_ack}, 32'd2);
        host_op(1'b0, 2'd0, 32'd0, d);
        chk(d === 32'd0, "R1", "control after reset", d, 32'd0);
        host_op(1'b0, 2'd2, 32'd0, d);
        chk(d === 32'd0, "R1", "offset after reset", d, 32'd0);
    endtask

    task automatic t_fill();
        logic [31:0] d;
        set_ctrl(1'b1, 1'b1, 8'd0);
        host_op(1'b0, 2'd0, 32'd0, d);
        chk(d === 32'hC000_0000, "R2", "control readback", d, 32'hC000_0000);
        host_op(1'b1, 2'd1, 32'hA0A1A2A3, d);
        host_op(1'b1, 2'd1, 32'hB0B1B2B3, d);
        host_op(1'b1, 2'd1, 32'hC0C1C2C3, d);
        host_op(1'b1, 2'd1, 32'hD0D1D2D3, d);
        expect_ptr(7'd4, "R3");
    endtask

    task automatic t_dir1_read();
        logic [31:0] d;
        set_ctrl(1'b1, 1'b1, 8'd2);
        host_op(1'b0, 2'd1, 32'd0, d);
        chk(d === 32'hC0C1C2C3, "R5", "dir1 read data", d, 32'hC0C1C2C3);
        expect_ptr(7'd2, "R5");
    endtask

    task automatic t_drain();
        logic [31:0] d;
        logic [31:0] exp [4] = '{32'hA0A1A2A3, 32'hB0B1B2B3, 32'hC0C1C2C3, 32'hD0D1D2D3};
        set_ctrl(1'b0, 1'b1, 8'd0);
        for (int i = 0; i < 4; i++) begin
            host_op(1'b0, 2'd1, 32'd0, d);
            chk(d === exp[i], "R4", "drain word", d, exp[i]);
        end
        expect_ptr(7'd4, "R4");
    endtask

    task automatic t_noinc();
        logic [31:0] d;
        set_ctrl(1'b1, 1'b0, 8'h85);
        expect_ptr(7'd5, "R2");
        host_op(1'b1, 2'd1, 32'h1111_1111, d);
        host_op(1'b1, 2'd1, 32'h2222_2222, d);
        expect_ptr(7'd5, "R3");
        set_ctrl(1'b0, 1'b0, 8'd5);
        host_op(1'b0, 2'd1, 32'd0, d);
        chk(d === 32'h2222_2222, "R3", "no-increment overwrite", d, 32'h2222_2222);
        expect_ptr(7'd5, "R4");
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        set_ctrl(1'b0, 1'b1, 8'd0);
        host_op(1'b1, 2'd1, 32'hDEAD_BEEF, d);
        expect_ptr(7'd0, "R6");
        host_op(1'b0, 2'd1, 32'd0, d);
        chk(d === 32'hA0A1A2A3, "R6", "word after ignored write", d, 32'hA0A1A2A3);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        set_ctrl(1'b1, 1'b1, 8'd127);
        host_op(1'b1, 2'd1, 32'h7788_99AA, d);
        expect_ptr(7'd0, "R7");
    endtask

    task automatic t_seq_le();
        logic [7:0] b;
        logic [31:0] d;
        logic [7:0] exp [4] = '{8'hA3, 8'hA2, 8'hA1, 8'hA0};
        host_op(1'b1, 2'd2, 32'd0, d);
        for (int i = 0; i < 4; i++) begin
            seq_op(i == 0, 1'b0, 8'd0, b);
            chk(b === exp[i], "R8", "seq read byte", 32'(b), 32'(exp[i]));
        end
        host_op(1'b1, 2'd2, 32'd8, d);
        host_op(1'b0, 2'd2, 32'd0, d);
        chk(d === 32'd8, "R9", "offset readback", d, 32'd8);
        seq_op(1'b1, 1'b1, 8'h11, b);
        seq_op(1'b0, 1'b1, 8'h22, b);
        seq_op(1'b0, 1'b1, 8'h33, b);
        seq_op(1'b0, 1'b1, 8'h44, b);
        set_ctrl(1'b0, 1'b0, 8'd2);
        host_op(1'b0, 2'd1, 32'd0, d);
        chk(d === 32'h4433_2211, "R8", "seq-written word", d, 32'h4433_2211);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] b;
        logic [31:0] d;
        host_op(1'b1, 2'd2, 32'd511, d);
        seq_op(1'b1, 1'b0, 8'd0, b);
        chk(b === 8'h77, "R9", "byte 511", 32'(b), 32'h77);
        seq_op(1'b0, 1'b0, 8'd0, b);
        chk(b === 8'hA3, "R9", "byte after wrap", 32'(b), 32'hA3);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        host_op(1'b1, 2'd2, 32'd4, d);
        set_ctrl(1'b0, 1'b1, 8'd0);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_sel = 2'd1;
        seq_en = 1'b1; seq_start = 1'b1; seq_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0; seq_en = 1'b0; seq_start = 1'b0;
        chk(seq_rvalid === 1'b1 && seq_rbyte === 8'hB3, "R10", "seq served first",
            {23'd0, seq_rvalid, seq_rbyte}, 32'h1B3);
        chk(host_ready === 1'b0 && host_ack === 1'b0, "R10", "host deferred",
            {30'd0, host_ready, host_ack}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(host_ack === 1'b1, "R10", "late ack", 32'(host_ack), 32'd1);
        chk(host_rdata === 32'hA0A1A2A3, "R10", "late data", host_rdata, 32'hA0A1A2A3);
        chk(host_ready === 1'b1, "R10", "ready again", 32'(host_ready), 32'd1);
        expect_ptr(7'd1, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_dir1_read();
        t_drain();
        t_noinc();
        t_ignore();
        t_wrap();
        t_seq_le();
        t_seq_wrap();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule